// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file reached through a 16-bit I/O port space. A bus master presents a port number together with a read or a write strobe. The block collects a handful of board-level control signals behind single ports: a soft-reset request, a byte-order mode, a disk-activity lamp, a four-bit cache-control field and an I/O address-map mode. Two ports do not store anything. A write to either of them sends a one-cycle toggle pulse to the lock logic of a non-volatile memory.

Several ports return fixed identification and equipment codes. Writes to the identification ports are accepted and dropped. A read of any port the block does not decode returns all ones. A write to such a port is dropped and raises a one-cycle error flag. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to port 0x0092 sets `soft_rst` from data bit 0 and `le_mode` from data bit 1, starting in the cycle after the write. Both hold until the next write to 0x0092.
- R2: A read of port 0x0092 returns 0x00, whatever was last written there.
- R3: Ports 0x0800, 0x0802 and 0x0803 read as 0xEF, 0xAD and 0xE0. A write to any of them changes no output and raises no error.
- R4: Port 0x080C reads 0x3C, port 0x0810 reads 0x39, port 0x0818 reads 0x00 and port 0x0823 reads 0x03.
- R5: A write to 0x0810 makes `nvlock_a` high for exactly the following cycle. A write to 0x0812 does the same on `nvlock_b`. The data value has no effect.
- R6: A write to 0x0808 sets `lamp_on` to data bit 0.
- R7: A write to 0x081C stores data bits 3:0 on `cache_ctl`. A read of 0x081C returns them with bits 7:4 zero.
- R8: A write to 0x0850 stores data bit 0 on `iomap_sparse` (0 = contiguous map, 1 = sparse map). A read of 0x0850 returns it in bit 0 with the other bits zero.
- R9: A write to 0x0814 is accepted, changes no output and raises no error.
- R10: A read of a port with no read decode returns 0xFF. This includes 0x0808, 0x0812, 0x0814 and every unlisted port. A write to a port with no write decode (0x080C, 0x0818, 0x0823 or any unlisted port) changes no state and makes `bad_access` high for the following cycle only.
- R11: While `rst_n` is low, all outputs are 0.
- R12: `io_rdata` updates only in the cycle after a read strobe and otherwise holds its value. When a read and a write occur in the same cycle, the read returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port number |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | Soft-reset request level |
| le_mode | output | 1 | Little-endian mode level |
| lamp_on | output | 1 | Disk-activity lamp |
| nvlock_a | output | 1 | One-cycle toggle pulse, memory lock line A |
| nvlock_b | output | 1 | One-cycle toggle pulse, memory lock line B |
| cache_ctl | output | 4 | Cache-control field |
| iomap_sparse | output | 1 | I/O map mode, 1 = sparse |
| bad_access | output | 1 | One-cycle flag for a dropped write |

## Verification
Every stored bit drives a port directly, so a corrupted control bit is visible on the output in the cycle after the faulty write. It stays visible until the next write to that port, and the model compares the outputs on every cycle. A decode error does not stay hidden. A wrong select either changes a level output, emits or suppresses a lock pulse, or flips `bad_access`, and each of these appears one cycle after the strobe. Read-path faults appear on `io_rdata` one cycle after the read strobe. Because the bench checks that the value holds between reads, a register that updates when it should not is also caught.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int CACHE_W = 4;

    // Port map
    localparam logic [ADDR_W-1:0] A_PORT92 = 16'h0092;
    localparam logic [ADDR_W-1:0] A_CPUID  = 16'h0800;
    localparam logic [ADDR_W-1:0] A_FEAT   = 16'h0802;
    localparam logic [ADDR_W-1:0] A_BSTAT  = 16'h0803;
    localparam logic [ADDR_W-1:0] A_LAMP   = 16'h0808;
    localparam logic [ADDR_W-1:0] A_EQUIP  = 16'h080C;
    localparam logic [ADDR_W-1:0] A_LOCKA  = 16'h0810;
    localparam logic [ADDR_W-1:0] A_LOCKB  = 16'h0812;
    localparam logic [ADDR_W-1:0] A_L2INV  = 16'h0814;
    localparam logic [ADDR_W-1:0] A_KEY    = 16'h0818;
    localparam logic [ADDR_W-1:0] A_CACHE  = 16'h081C;
    localparam logic [ADDR_W-1:0] A_L2STAT = 16'h0823;
    localparam logic [ADDR_W-1:0] A_MAP    = 16'h0850;

    // Fixed read values
    localparam logic [DATA_W-1:0] V_CPUID  = 8'hEF;
    localparam logic [DATA_W-1:0] V_FEAT   = 8'hAD;
    localparam logic [DATA_W-1:0] V_BSTAT  = 8'hE0;
    localparam logic [DATA_W-1:0] V_EQUIP  = 8'h3C;
    localparam logic [DATA_W-1:0] V_EXTFT  = 8'h39;
    localparam logic [DATA_W-1:0] V_KEY    = 8'h00;
    localparam logic [DATA_W-1:0] V_L2STAT = 8'h03;
    localparam logic [DATA_W-1:0] V_ZERO   = '0;
    localparam logic [DATA_W-1:0] V_FLOAT  = '1;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PORT92,
        SEL_CPUID,
        SEL_FEAT,
        SEL_BSTAT,
        SEL_LAMP,
        SEL_EQUIP,
        SEL_LOCKA,
        SEL_LOCKB,
        SEL_L2INV,
        SEL_KEY,
        SEL_CACHE,
        SEL_L2STAT,
        SEL_MAP
    } port_sel_e;

    typedef struct packed {
        logic               soft_rst;
        logic               le_mode;
        logic               lamp;
        logic [CACHE_W-1:0] cache;
        logic               sparse;
    } ctl_state_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel
);

    always_comb begin
        unique case (addr)
            A_PORT92: sel = SEL_PORT92;
            A_CPUID:  sel = SEL_CPUID;
            A_FEAT:   sel = SEL_FEAT;
            A_BSTAT:  sel = SEL_BSTAT;
            A_LAMP:   sel = SEL_LAMP;
            A_EQUIP:  sel = SEL_EQUIP;
            A_LOCKA:  sel = SEL_LOCKA;
            A_LOCKB:  sel = SEL_LOCKB;
            A_L2INV:  sel = SEL_L2INV;
            A_KEY:    sel = SEL_KEY;
            A_CACHE:  sel = SEL_CACHE;
            A_L2STAT: sel = SEL_L2STAT;
            A_MAP:    sel = SEL_MAP;
            default:  sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  port_sel_e         sel,
    input  logic [DATA_W-1:0] wdata,
    output ctl_state_t        state,
    output logic              lock_a,
    output logic              lock_b,
    output logic              bad_wr
);

    typedef struct packed {
        ctl_state_t st;
        logic       lock_a;
        logic       lock_b;
        logic       bad;
    } ctrl_reg_t;

    ctrl_reg_t r_d, r_q;

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CACHE_W];

    always_comb begin
        r_d        = r_q;
        r_d.lock_a = 1'b0;
        r_d.lock_b = 1'b0;
        r_d.bad    = 1'b0;
        if (wr) begin
            unique case (sel)
                SEL_PORT92: begin
                    r_d.st.soft_rst = wdata[0];
                    r_d.st.le_mode  = wdata[1];
                end
                SEL_LAMP:  r_d.st.lamp   = wdata[0];
                SEL_LOCKA: r_d.lock_a    = 1'b1;
                SEL_LOCKB: r_d.lock_b    = 1'b1;
                SEL_CACHE: r_d.st.cache  = wdata[CACHE_W-1:0];
                SEL_MAP:   r_d.st.sparse = wdata[0];
                SEL_CPUID, SEL_FEAT, SEL_BSTAT, SEL_L2INV: begin
                    // accepted, no side effect
                end
                default:   r_d.bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state  = r_q.st;
    assign lock_a = r_q.lock_a;
    assign lock_b = r_q.lock_b;
    assign bad_wr = r_q.bad;

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  port_sel_e         sel,
    input  ctl_state_t        state,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [DATA_W-1:0] lookup;

    always_comb begin
        unique case (sel)
            SEL_PORT92: lookup = V_ZERO;
            SEL_CPUID:  lookup = V_CPUID;
            SEL_FEAT:   lookup = V_FEAT;
            SEL_BSTAT:  lookup = V_BSTAT;
            SEL_EQUIP:  lookup = V_EQUIP;
            SEL_LOCKA:  lookup = V_EXTFT;
            SEL_KEY:    lookup = V_KEY;
            SEL_L2STAT: lookup = V_L2STAT;
            SEL_CACHE:  lookup = {{(DATA_W-CACHE_W){1'b0}}, state.cache};
            SEL_MAP:    lookup = {{(DATA_W-1){1'b0}}, state.sparse};
            default:    lookup = V_FLOAT;
        endcase
        rdata_d = rd ? lookup : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic [DATA_W-1:0]  io_wdata,
    output logic [DATA_W-1:0]  io_rdata,
    output logic               soft_rst,
    output logic               le_mode,
    output logic               lamp_on,
    output logic               nvlock_a,
    output logic               nvlock_b,
    output logic [CACHE_W-1:0] cache_ctl,
    output logic               iomap_sparse,
    output logic               bad_access
);

    port_sel_e  sel;
    ctl_state_t st;

    sysctl_decode u_decode (
        .addr (io_addr),
        .sel  (sel)
    );

    sysctl_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (io_wr),
        .sel    (sel),
        .wdata  (io_wdata),
        .state  (st),
        .lock_a (nvlock_a),
        .lock_b (nvlock_b),
        .bad_wr (bad_access)
    );

    sysctl_rdmux u_rdmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (io_rd),
        .sel   (sel),
        .state (st),
        .rdata (io_rdata)
    );

    assign soft_rst     = st.soft_rst;
    assign le_mode      = st.le_mode;
    assign lamp_on      = st.lamp;
    assign cache_ctl    = st.cache;
    assign iomap_sparse = st.sparse;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  io_addr,
    input logic               io_rd,
    input logic               io_wr,
    input logic [DATA_W-1:0]  io_rdata,
    input logic               soft_rst,
    input logic               le_mode,
    input logic               lamp_on,
    input logic               nvlock_a,
    input logic               nvlock_b,
    input logic [CACHE_W-1:0] cache_ctl,
    input logic               iomap_sparse,
    input logic               bad_access
);

    p_port92_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == A_PORT92) |=> $stable(soft_rst) && $stable(le_mode));

    p_port92_rd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == A_PORT92) |=> io_rdata == 8'h00);

    p_cpuid_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == A_CPUID) |=> io_rdata == 8'hEF);

    p_lock_a_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_LOCKA) |=> nvlock_a);

    p_lock_b_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nvlock_b |-> $past(io_wr && io_addr == A_LOCKB));

    p_lamp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == A_LAMP) |=> $stable(lamp_on));

    p_cache_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == A_CACHE) |=> $stable(cache_ctl));

    p_map_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == A_MAP) |=> $stable(iomap_sparse));

    p_undec_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr[15:12] != 4'h0) |=> io_rdata == 8'hFF);

    p_bad_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(io_wr));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .io_rdata     (io_rdata),
    .soft_rst     (soft_rst),
    .le_mode      (le_mode),
    .lamp_on      (lamp_on),
    .nvlock_a     (nvlock_a),
    .nvlock_b     (nvlock_b),
    .cache_ctl    (cache_ctl),
    .iomap_sparse (iomap_sparse),
    .bad_access   (bad_access)
);

// File: tb/sysctl_regfile_tb_top.sv
module sysctl_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        soft_rst, le_mode, lamp_on, nvlock_a, nvlock_b, iomap_sparse, bad_access;
    logic [3:0]  cache_ctl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic       m_srst = 0, m_le = 0, m_lamp = 0, m_map = 0;
    logic [3:0] m_cache = 0;
    logic [7:0] m_rdata = 0;
    logic       m_la = 0, m_lb = 0, m_bad = 0;

    always #2.5 clk = ~clk;

    sysctl_regfile dut_i (
        .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_rd (io_rd),
        .io_wr (io_wr), .io_wdata (io_wdata), .io_rdata (io_rdata),
        .soft_rst (soft_rst), .le_mode (le_mode), .lamp_on (lamp_on),
        .nvlock_a (nvlock_a), .nvlock_b (nvlock_b), .cache_ctl (cache_ctl),
        .iomap_sparse (iomap_sparse), .bad_access (bad_access)
    );

    function automatic logic [7:0] rd_val(input logic [15:0] a);
        case (a)
            16'h0092: return 8'h00;
            16'h0800: return 8'hEF;
            16'h0802: return 8'hAD;
            16'h0803: return 8'hE0;
            16'h080C: return 8'h3C;
            16'h0810: return 8'h39;
            16'h0818: return 8'h00;
            16'h0823: return 8'h03;
            16'h081C: return {4'h0, m_cache};
            16'h0850: return {7'h0, m_map};
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic string rd_req(input logic [15:0] a);
        case (a)
            16'h0092: return "R2";
            16'h0800, 16'h0802, 16'h0803: return "R3";
            16'h080C, 16'h0810, 16'h0818, 16'h0823: return "R4";
            16'h081C: return "R7";
            16'h0850: return "R8";
            default:  return "R10";
        endcase
    endfunction

    function automatic bit wr_ok(input logic [15:0] a);
        case (a)
            16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808,
            16'h0810, 16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string wr_req(input logic [15:0] a);
        case (a)
            16'h0800, 16'h0802, 16'h0803: return "R3";
            16'h0814: return "R9";
            default:  return "R10";
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string rdreq, input string badreq);
        chk(io_rdata, m_rdata, rdreq);
        chk({6'h0, le_mode, soft_rst}, {6'h0, m_le, m_srst}, "R1");
        chk({7'h0, lamp_on}, {7'h0, m_lamp}, "R6");
        chk({4'h0, cache_ctl}, {4'h0, m_cache}, "R7");
        chk({7'h0, iomap_sparse}, {7'h0, m_map}, "R8");
        chk({6'h0, nvlock_b, nvlock_a}, {6'h0, m_lb, m_la}, "R5");
        chk({7'h0, bad_access}, {7'h0, m_bad}, badreq);
    endtask

    // One bus cycle; called at a falling edge, returns at the next one
    task automatic op(input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d);
        string rq, bq;
        io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
        rq = rd ? rd_req(a) : "R12";
        bq = wr ? wr_req(a) : "R10";
        if (rd) m_rdata = rd_val(a);
        m_la  = wr && a == 16'h0810;
        m_lb  = wr && a == 16'h0812;
        m_bad = wr && !wr_ok(a);
        if (wr) begin
            case (a)
                16'h0092: begin m_srst = d[0]; m_le = d[1]; end
                16'h0808: m_lamp = d[0];
                16'h081C: m_cache = d[3:0];
                16'h0850: m_map = d[0];
                default: ;
            endcase
        end
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        chk_all(rq, bq);
    endtask

    localparam logic [15:0] PORTS [13] = '{16'h0092, 16'h0800, 16'h0802, 16'h0803,
        16'h0808, 16'h080C, 16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C,
        16'h0823, 16'h0850};

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R11: reset state
        chk_all("R11", "R11");
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R11", "R11");

        // directed corners
        op(0, 1, 16'h0092, 8'h03);          // R1 set both
        op(1, 0, 16'h0092, 8'h00);          // R2 reads zero
        op(0, 0, 16'h0000, 8'h00);          // R12 hold
        op(0, 1, 16'h0800, 8'hFF);          // R3 write ignored
        op(0, 1, 16'h0803, 8'h00);
        op(1, 0, 16'h0802, 8'h00);          // R3
        op(0, 1, 16'h0814, 8'hFF);          // R9
        op(0, 1, 16'h0810, 8'h00);          // R5 pulse a
        op(0, 1, 16'h0812, 8'hA5);          // R5 pulse b
        op(0, 0, 16'h0000, 8'h00);          // R5 pulse gone
        op(0, 1, 16'h081C, 8'hFA);          // R7 low nibble only
        op(1, 0, 16'h081C, 8'h00);
        op(0, 1, 16'h0850, 8'hFF);          // R8
        op(1, 0, 16'h0850, 8'h00);
        op(0, 1, 16'h0808, 8'h01);          // R6
        op(1, 0, 16'h0808, 8'h00);          // R10 write-only port reads FF
        op(0, 1, 16'h080C, 8'h00);          // R10 bad write
        op(0, 1, 16'h1234, 8'hFF);          // R10
        op(1, 1, 16'h081C, 8'h05);          // R12 read sees old state
        op(1, 0, 16'h0823, 8'h00);          // R4
        op(0, 1, 16'h0092, 8'h02);          // R1 partial

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            int kind;
            kind = $urandom % 4;
            a = ($urandom % 8 == 0) ? 16'($urandom) : PORTS[$urandom % 13];
            op(kind == 1 || kind == 3, kind == 2 || kind == 3, a, 8'($urandom));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200us;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule